// File: doc/BRIEF.md
# Memory Data Alignment Unit

This unit sits between a 32-bit memory data port and the register file of a small RISC core. On loads it picks the addressed byte, halfword or word out of the returned memory word. It sign- or zero-extends narrow results. For the two explicit unaligned-load operations it also merges a partial word into the old destination register value. The load result is registered and leaves one cycle after the request, together with a valid strobe.

On stores it copies the source data into the right byte lanes and raises the byte enables. It does this combinationally, in the same cycle as the request. A run-time input selects the byte order. Ordinary halfword and word accesses at misaligned addresses are never repaired. The unit raises a flag for the core and suppresses the access.

Opcode encoding on `req_op`:

| Code | Operation |
|---|---|
| 0 | signed byte load |
| 1 | unsigned byte load |
| 2 | signed halfword load |
| 3 | unsigned halfword load |
| 4 | word load |
| 5 | left-merge load |
| 6 | right-merge load |
| 8 | byte store |
| 9 | halfword store |
| 10 | word store |
| 11 | left store |
| 12 | right store |

All other codes do nothing. In the requirements, "offset" means `req_addr`. Offset k sits in bits [8k+7:8k] when `big_endian`=0 and in bits [31-8k:24-8k] when `big_endian`=1. m[k] is the memory byte at offset k.

Top module: `lsu_align`

## Requirements
- R1: After reset `ld_valid`=0 and `ld_data`=0. An accepted load gives `ld_valid`=1 with its result exactly one cycle later. A word load (code 4) yields {m3,m2,m1,m0} in little-endian and {m0,m1,m2,m3} in big-endian.
- R2: A byte load returns m[offset]. Code 0 copies bit 7 into bits 31:8, and code 1 clears them.
- R3: A halfword load at an even offset a returns {m[a+1],m[a]} in little-endian and {m[a],m[a+1]} in big-endian. Code 2 sign-extends the result and code 3 zero-extends it.
- R4: With `req_valid`=1, `misalign` is 1 in the same cycle for codes 2, 3 and 9 at an odd offset, and for codes 4 and 10 at a non-zero offset; otherwise it is 0. A flagged request drives `mem_be`=0 and produces no `ld_valid`.
- R5: Code 5 puts m[a] into result bits 31:24, then the next memory bytes into the next lower result bytes. It stops at offset 0 in little-endian and offset 3 in big-endian. Result bytes it does not reach keep `old_reg`.
- R6: Code 6 puts m[a] into result bits 7:0, then the next memory bytes into the next higher result bytes. It stops at offset 3 in little-endian and offset 0 in big-endian. The other result bytes keep `old_reg`.
- R7: A byte store enables only the lane of the offset and carries `st_data[7:0]` there.
- R8: A halfword store at an even offset a asserts exactly two adjacent enables in one access. In little-endian the stored value is {m[a+1],m[a]} = `st_data[15:0]`; in big-endian it is {m[a],m[a+1]}.
- R9: A word store at offset 0 enables all four lanes. Its byte order mirrors R1.
- R10: Code 11 writes `st_data[31:24]` to offset a, then the next lower source bytes to the following offsets, toward offset 0 (little-endian) or offset 3 (big-endian). Code 12 writes `st_data[7:0]` to offset a, then the next higher source bytes the other way. Only those offsets are enabled.
- R11: Load codes, undefined codes and `req_valid`=0 drive `mem_be`=0. Store codes and undefined codes never raise `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | input | 1 | request present this cycle |
| req_op | input | 4 | operation code |
| req_addr | input | 2 | byte offset within the word |
| big_endian | input | 1 | byte order select |
| st_data | input | 32 | store source register |
| old_reg | input | 32 | current destination register value for merge loads |
| mem_rdata | input | 32 | memory read word, valid with the load request |
| mem_be | output | 4 | store byte enables |
| mem_wdata | output | 32 | store data arranged by lane |
| misalign | output | 1 | misaligned ordinary access |
| ld_valid | output | 1 | registered load result valid |
| ld_data | output | 32 | registered load result |

## Verification
A wrong lane or shift amount inside the unit shows up as a wrong byte. For stores that happens in the same cycle, on `mem_wdata` or `mem_be`. For loads it happens one cycle later, on `ld_data`. A mistaken merge boundary leaves a register byte kept or replaced at the wrong point, and walking every offset in both byte orders exposes it. A wrong misalignment decision shows at once on `misalign` and `mem_be`, and one cycle later as a missing or extra `ld_valid`.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam logic [3:0] OP_LD_BS    = 4'd0;
  localparam logic [3:0] OP_LD_BU    = 4'd1;
  localparam logic [3:0] OP_LD_HS    = 4'd2;
  localparam logic [3:0] OP_LD_HU    = 4'd3;
  localparam logic [3:0] OP_LD_W     = 4'd4;
  localparam logic [3:0] OP_LD_LEFT  = 4'd5;
  localparam logic [3:0] OP_LD_RIGHT = 4'd6;
  localparam logic [3:0] OP_ST_B     = 4'd8;
  localparam logic [3:0] OP_ST_H     = 4'd9;
  localparam logic [3:0] OP_ST_W     = 4'd10;
  localparam logic [3:0] OP_ST_LEFT  = 4'd11;
  localparam logic [3:0] OP_ST_RIGHT = 4'd12;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_BYTE  = 3'd1,
    K_HALF  = 3'd2,
    K_WORD  = 3'd3,
    K_LEFT  = 3'd4,
    K_RIGHT = 3'd5
  } acc_kind_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      sign_ext;
    acc_kind_e kind;
  } acc_dec_t;

  function automatic acc_dec_t acc_decode(input logic [3:0] op);
    acc_dec_t d;
    d.is_load  = 1'b0;
    d.is_store = 1'b0;
    d.sign_ext = 1'b0;
    d.kind     = K_NONE;
    case (op)
      OP_LD_BS:    begin d.is_load = 1'b1; d.sign_ext = 1'b1; d.kind = K_BYTE;  end
      OP_LD_BU:    begin d.is_load = 1'b1;                    d.kind = K_BYTE;  end
      OP_LD_HS:    begin d.is_load = 1'b1; d.sign_ext = 1'b1; d.kind = K_HALF;  end
      OP_LD_HU:    begin d.is_load = 1'b1;                    d.kind = K_HALF;  end
      OP_LD_W:     begin d.is_load = 1'b1;                    d.kind = K_WORD;  end
      OP_LD_LEFT:  begin d.is_load = 1'b1;                    d.kind = K_LEFT;  end
      OP_LD_RIGHT: begin d.is_load = 1'b1;                    d.kind = K_RIGHT; end
      OP_ST_B:     begin d.is_store = 1'b1;                   d.kind = K_BYTE;  end
      OP_ST_H:     begin d.is_store = 1'b1;                   d.kind = K_HALF;  end
      OP_ST_W:     begin d.is_store = 1'b1;                   d.kind = K_WORD;  end
      OP_ST_LEFT:  begin d.is_store = 1'b1;                   d.kind = K_LEFT;  end
      OP_ST_RIGHT: begin d.is_store = 1'b1;                   d.kind = K_RIGHT; end
      default:     d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
// Maps the byte offset and byte order onto physical lanes and decides
// misalignment. Word significance i always lives in lane i, so only the
// position of a narrow item depends on the byte order.
module lsu_lane_map
  import lsu_align_pkg::*;
#(
  parameter int NB    = 4,
  parameter int OFF_W = $clog2(NB)
) (
  input  logic             valid,
  input  acc_dec_t         dec,
  input  logic [OFF_W-1:0] addr,
  input  logic             big_endian,
  output logic [OFF_W-1:0] byte_lane,
  output logic [OFF_W-1:0] half_lane,
  output logic [OFF_W-1:0] inv_lane,
  output logic             misalign
);

  localparam logic [OFF_W-1:0] TOP_LANE  = OFF_W'(NB - 1);
  localparam logic [OFF_W-1:0] HALF_BASE = OFF_W'(NB - 2);

  always_comb begin
    byte_lane = big_endian ? (TOP_LANE - addr) : addr;
    half_lane = big_endian ? (HALF_BASE - addr) : addr;
    inv_lane  = TOP_LANE - byte_lane;
  end

  always_comb begin
    misalign = 1'b0;
    if (valid && (dec.is_load || dec.is_store)) begin
      case (dec.kind)
        K_HALF:  misalign = addr[0];
        K_WORD:  misalign = (addr != '0);
        default: misalign = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_path.sv
// Load side: extracts and extends narrow items and merges partial words
// into the old register value.
module lsu_load_path
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int OFF_W  = $clog2(NB)
) (
  input  acc_kind_e         kind,
  input  logic              sign_ext,
  input  logic [OFF_W-1:0]  byte_lane,
  input  logic [OFF_W-1:0]  half_lane,
  input  logic [OFF_W-1:0]  inv_lane,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] old_reg,
  output logic [DATA_W-1:0] result
);

  logic [7:0]        byte_v;
  logic [15:0]       half_v;
  logic [DATA_W-1:0] left_sh;
  logic [DATA_W-1:0] right_sh;
  logic [DATA_W-1:0] left_mrg;
  logic [DATA_W-1:0] right_mrg;
  logic [NB-1:0]     left_take;
  logic [NB-1:0]     right_take;

  always_comb begin
    byte_v   = rdata[{byte_lane, 3'b000} +: 8];
    half_v   = rdata[{half_lane, 3'b000} +: 16];
    left_sh  = rdata << {inv_lane, 3'b000};
    right_sh = rdata >> {byte_lane, 3'b000};
  end

  // Per-byte choice between shifted memory data and the old register byte.
  for (genvar j = 0; j < NB; j++) begin : g_merge
    assign left_take[j]  = (OFF_W'(j) >= inv_lane);
    assign right_take[j] = (OFF_W'(j) <= inv_lane);
    assign left_mrg[8*j +: 8]  = left_take[j]  ? left_sh[8*j +: 8]  : old_reg[8*j +: 8];
    assign right_mrg[8*j +: 8] = right_take[j] ? right_sh[8*j +: 8] : old_reg[8*j +: 8];
  end

  always_comb begin
    case (kind)
      K_BYTE:  result = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
      K_HALF:  result = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
      K_WORD:  result = rdata;
      K_LEFT:  result = left_mrg;
      K_RIGHT: result = right_mrg;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/lsu_store_path.sv
// Store side: lane replication, shifting and byte enables.
module lsu_store_path
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int OFF_W  = $clog2(NB)
) (
  input  logic              active,
  input  acc_kind_e         kind,
  input  logic [OFF_W-1:0]  byte_lane,
  input  logic [OFF_W-1:0]  half_lane,
  input  logic [OFF_W-1:0]  inv_lane,
  input  logic [DATA_W-1:0] st_data,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);

  localparam int NH = NB / 2;

  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;
  logic [NB-1:0]     left_en;
  logic [NB-1:0]     right_en;

  for (genvar j = 0; j < NB; j++) begin : g_rep_b
    assign rep_byte[8*j +: 8] = st_data[7:0];
    assign left_en[j]  = (OFF_W'(j) <= byte_lane);
    assign right_en[j] = (OFF_W'(j) >= byte_lane);
  end

  for (genvar h = 0; h < NH; h++) begin : g_rep_h
    assign rep_half[16*h +: 16] = st_data[15:0];
  end

  always_comb begin
    be    = '0;
    wdata = '0;
    if (active) begin
      case (kind)
        K_BYTE: begin
          be    = NB'(1) << byte_lane;
          wdata = rep_byte;
        end
        K_HALF: begin
          be    = NB'(3) << half_lane;
          wdata = rep_half;
        end
        K_WORD: begin
          be    = '1;
          wdata = st_data;
        end
        K_LEFT: begin
          be    = left_en;
          wdata = st_data >> {inv_lane, 3'b000};
        end
        K_RIGHT: begin
          be    = right_en;
          wdata = st_data << {byte_lane, 3'b000};
        end
        default: begin
          be    = '0;
          wdata = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int OFF_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [OFF_W-1:0]  req_addr,
  input  logic              big_endian,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] old_reg,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  acc_dec_t          dec;
  logic [OFF_W-1:0]  byte_lane;
  logic [OFF_W-1:0]  half_lane;
  logic [OFF_W-1:0]  inv_lane;
  logic [DATA_W-1:0] load_res;
  logic              st_active;
  logic              ld_accept;

  assign dec = acc_decode(req_op);

  lsu_lane_map #(.NB(NB), .OFF_W(OFF_W)) u_lane_map (
    .valid      (req_valid),
    .dec        (dec),
    .addr       (req_addr),
    .big_endian (big_endian),
    .byte_lane  (byte_lane),
    .half_lane  (half_lane),
    .inv_lane   (inv_lane),
    .misalign   (misalign)
  );

  lsu_load_path #(.DATA_W(DATA_W), .NB(NB), .OFF_W(OFF_W)) u_load_path (
    .kind      (dec.kind),
    .sign_ext  (dec.sign_ext),
    .byte_lane (byte_lane),
    .half_lane (half_lane),
    .inv_lane  (inv_lane),
    .rdata     (mem_rdata),
    .old_reg   (old_reg),
    .result    (load_res)
  );

  assign st_active = req_valid & dec.is_store & ~misalign;
  assign ld_accept = req_valid & dec.is_load & ~misalign;

  lsu_store_path #(.DATA_W(DATA_W), .NB(NB), .OFF_W(OFF_W)) u_store_path (
    .active    (st_active),
    .kind      (dec.kind),
    .byte_lane (byte_lane),
    .half_lane (half_lane),
    .inv_lane  (inv_lane),
    .st_data   (st_data),
    .be        (mem_be),
    .wdata     (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_accept;
      if (ld_accept) ld_data <= load_res;
    end
  end

  // R1: an accepted load yields a valid result on the next cycle
  p_ld_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dec.is_load && !misalign) |=> ld_valid);

  // R4: a flagged access writes nothing and returns nothing
  p_misalign_no_be_r4: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (mem_be == '0));
  p_misalign_no_result_r4: assert property (@(posedge clk) disable iff (rst)
    misalign |=> !ld_valid);

  // R2: unsigned byte load leaves upper bits clear
  p_byte_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && $past(req_op) == OP_LD_BU) |-> (ld_data[DATA_W-1:8] == '0));

  // R7: a byte store touches exactly one lane
  p_byte_store_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_ST_B) |-> ($countones(mem_be) == 1));

  // R8: a halfword store is one access with two neighbouring lanes
  p_half_store_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_ST_H && !misalign) |->
      ($countones(mem_be) == 2 && (mem_be & (mem_be >> 1)) != '0));

  // R11: loads never drive byte enables, stores never produce a result
  p_load_no_be_r11: assert property (@(posedge clk) disable iff (rst)
    dec.is_load |-> (mem_be == '0));
  p_store_no_result_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dec.is_store) |=> !ld_valid);

endmodule

// File: tb/test_lsu_align.sv
module test_lsu_align;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] LD_BS = 4'd0, LD_BU = 4'd1, LD_HS = 4'd2, LD_HU = 4'd3,
                         LD_W = 4'd4, LD_L = 4'd5, LD_R = 4'd6,
                         ST_B = 4'd8, ST_H = 4'd9, ST_W = 4'd10,
                         ST_L = 4'd11, ST_R = 4'd12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd15;
  logic [1:0]  req_addr = 2'd0;
  logic        big_endian = 1'b0;
  logic [31:0] st_data = '0;
  logic [31:0] old_reg = '0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        ld_valid;
  logic [31:0] ld_data;

  int checks = 0;
  int failures = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align i_lsu_align (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .big_endian(big_endian), .st_data(st_data),
    .old_reg(old_reg), .mem_rdata(mem_rdata), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] w, input int k, input logic bem);
    return bem ? w[31-8*k -: 8] : w[8*k +: 8];
  endfunction

  function automatic int lane_of(input int k, input logic bem);
    return bem ? 3 - k : k;
  endfunction

  function automatic logic [31:0] exp_load(input logic [3:0] op, input int a, input logic bem,
                                           input logic [31:0] rd, input logic [31:0] old);
    logic [31:0] r;
    logic [15:0] h;
    int j, k;
    r = old;
    h = bem ? {mb(rd, a, bem), mb(rd, a+1, bem)} : {mb(rd, a+1, bem), mb(rd, a, bem)};
    case (op)
      LD_BS: r = {{24{mb(rd, a, bem) >> 7}}, mb(rd, a, bem)} ;
      LD_BU: r = {24'd0, mb(rd, a, bem)};
      LD_HS: r = {{16{h[15]}}, h};
      LD_HU: r = {16'd0, h};
      LD_W:  r = bem ? {mb(rd,0,bem), mb(rd,1,bem), mb(rd,2,bem), mb(rd,3,bem)}
                     : {mb(rd,3,bem), mb(rd,2,bem), mb(rd,1,bem), mb(rd,0,bem)};
      LD_L: begin
        j = 3; k = a;
        while (j >= 0 && k >= 0 && k <= 3) begin
          r[8*j +: 8] = mb(rd, k, bem); j--; k = bem ? k + 1 : k - 1;
        end
      end
      LD_R: begin
        j = 0; k = a;
        while (j <= 3 && k >= 0 && k <= 3) begin
          r[8*j +: 8] = mb(rd, k, bem); j++; k = bem ? k - 1 : k + 1;
        end
      end
      default: r = '0;
    endcase
    if (op == LD_BS) r[31:8] = {24{r[7]}};
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      LD_BS, LD_BU: return "R2";
      LD_HS, LD_HU: return "R3";
      LD_W:         return "R1";
      LD_L:         return "R5";
      LD_R:         return "R6";
      ST_B:         return "R7";
      ST_H:         return "R8";
      ST_W:         return "R9";
      ST_L, ST_R:   return "R10";
      default:      return "R11";
    endcase
  endfunction

  task automatic do_op(input logic vld, input logic [3:0] op, input int a, input logic bem,
                       input logic [31:0] sd, input logic [31:0] old, input logic [31:0] rd);
    logic mis_e, is_ld, is_st;
    logic [3:0] eb;
    logic [31:0] ed;
    int j, k, ln;
    string t;
    @(negedge clk);
    req_valid = vld; req_op = op; req_addr = 2'(a); big_endian = bem;
    st_data = sd; old_reg = old; mem_rdata = rd;
    #1;
    is_ld = (op <= LD_R);
    is_st = (op >= ST_B && op <= ST_R);
    mis_e = vld && ((((op == LD_HS) || (op == LD_HU) || (op == ST_H)) && a[0]) ||
                    (((op == LD_W) || (op == ST_W)) && a != 0));
    check(misalign == mis_e, "R4 misalign", 32'(misalign), 32'(mis_e));
    eb = '0; ed = '0;
    if (vld && is_st && !mis_e) begin
      case (op)
        ST_B: begin ln = lane_of(a, bem); eb[ln] = 1'b1; ed[8*ln +: 8] = sd[7:0]; end
        ST_H: begin
          ln = lane_of(a, bem);   eb[ln] = 1'b1; ed[8*ln +: 8] = bem ? sd[15:8] : sd[7:0];
          ln = lane_of(a+1, bem); eb[ln] = 1'b1; ed[8*ln +: 8] = bem ? sd[7:0] : sd[15:8];
        end
        ST_W: for (int q = 0; q < 4; q++) begin
          ln = lane_of(q, bem); eb[ln] = 1'b1;
          ed[8*ln +: 8] = bem ? sd[8*(3-q) +: 8] : sd[8*q +: 8];
        end
        ST_L: begin
          j = 3; k = a;
          while (j >= 0 && k >= 0 && k <= 3) begin
            ln = lane_of(k, bem); eb[ln] = 1'b1; ed[8*ln +: 8] = sd[8*j +: 8];
            j--; k = bem ? k + 1 : k - 1;
          end
        end
        default: begin
          j = 0; k = a;
          while (j <= 3 && k >= 0 && k <= 3) begin
            ln = lane_of(k, bem); eb[ln] = 1'b1; ed[8*ln +: 8] = sd[8*j +: 8];
            j++; k = bem ? k - 1 : k + 1;
          end
        end
      endcase
    end
    t = mis_e ? "R4" : (vld && is_st) ? tag_of(op) : "R11";
    check(mem_be == eb, {t, " be"}, 32'(mem_be), 32'(eb));
    for (int q = 0; q < 4; q++)
      if (eb[q]) check(mem_wdata[8*q +: 8] == ed[8*q +: 8], {t, " lane data"},
                       32'(mem_wdata[8*q +: 8]), 32'(ed[8*q +: 8]));
    if (vld && is_ld && !mis_e) begin
      exp_q.push_back(exp_load(op, a, bem, rd, old));
      tag_q.push_back(tag_of(op));
    end
  endtask

  // Monitor: compares each registered load result with the scoreboard head.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (ld_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R11 unexpected ld_valid", ld_data, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ld_data == e, {t, " load result"}, ld_data, e);
        end
      end else if (exp_q.size() != 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(1'b0, {"R1 missing ld_valid for ", t}, 32'd0, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [31:0] RD  = 32'h8A7B_C69D;
  localparam logic [31:0] RD2 = 32'h1F80_7F02;
  localparam logic [31:0] OLD = 32'h5566_7788;
  localparam logic [31:0] SD  = 32'hA1B2_C3D4;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ld_valid == 1'b0, "R1 reset ld_valid", 32'(ld_valid), 32'd0);
    check(ld_data == 32'd0, "R1 reset ld_data", ld_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int e = 0; e < 2; e++) begin
      do_op(1'b1, LD_W, 0, 1'(e), SD, OLD, RD);
      do_op(1'b1, LD_W, 0, 1'(e), SD, OLD, RD2);
      for (int a = 0; a < 4; a++) begin
        do_op(1'b1, LD_BS, a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_BU, a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_L,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_R,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, ST_B,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, ST_L,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, ST_R,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_HS, a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_HU, a, 1'(e), SD, OLD, RD2);
        do_op(1'b1, ST_H,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, ST_W,  a, 1'(e), SD, OLD, RD);
        do_op(1'b1, LD_W,  a, 1'(e), SD, OLD, RD);
      end
      do_op(1'b1, LD_BS, 1, 1'(e), SD, OLD, RD2);
      do_op(1'b1, LD_HS, 2, 1'(e), SD, OLD, RD2);
      do_op(1'b1, 4'd7,  0, 1'(e), SD, OLD, RD);
      do_op(1'b1, 4'd13, 2, 1'(e), SD, OLD, RD);
      do_op(1'b0, ST_W,  0, 1'(e), SD, OLD, RD);
      do_op(1'b0, LD_W,  0, 1'(e), SD, OLD, RD);
    end

    do_op(1'b0, 4'd15, 0, 1'b0, '0, '0, '0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule